// File: doc/BRIEF.md
# Reorder Buffer with Tag-Broadcast Operand Capture

This block is the in-flight instruction store of a small out-of-order core that runs ALU operations only. It is a circular queue. Each dispatched instruction takes the slot at the tail, and the index of that slot becomes the rename tag for the instruction's result. The slot also acts as the reservation station. It holds the two source operands, either as values or as tags of older producers that have not yet finished. While an operand is waiting, the slot watches the result bus and copies the value in when the matching tag is broadcast.

Each cycle, the oldest slot whose operands are both present and which has not yet been sent is handed to a single external ALU. The ALU returns the result with the slot's tag on the broadcast bus. The result completes the producing slot and also wakes up any waiting consumers. Completed slots leave from the head strictly in program order. Each one presents its destination register and value for one cycle. A global flush clears every slot, for example when the head instruction faults.

The pointers carry an extra wrap bit, so a full buffer can be told apart from an empty one. The depth must be a power of two.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `iss_valid` and `ret_valid` are 0.
- R2: An accepted dispatch is written at the tail. `disp_tag` shows the tail slot index, which is the result tag, and successive accepted dispatches receive consecutive tags modulo the depth.
- R3: When all ROB_DEPTH slots are occupied, `disp_ready` is 0 and a dispatch request leaves the buffer and `disp_tag` unchanged.
- R4: A slot is offered on the issue port only when both of its source operands are present. The port shows the slot tag, operand values and op code.
- R5: When several slots are ready, the one nearest the head in program order is issued. At most one slot is issued per cycle, and the ALU always accepts it.
- R6: A result with `res_valid`=1 is copied into every occupied slot's waiting source whose tag equals `res_tag`, and that source becomes present.
- R7: A dispatched source that is marked not ready, and whose tag equals the `res_tag` of a result on the bus in the same cycle, is stored as present with that result value.
- R8: A result completes the occupied slot whose index equals `res_tag` and stores its value there. A result arriving in the cycle of a flush has no effect.
- R9: The head slot retires only once it is complete. `ret_valid` is then 1 for that cycle with its destination and value, and the head moves on by one, so retirement follows dispatch order.
- R10: A flush empties the buffer in the next cycle. A dispatch requested in the flush cycle is dropped.
- R11: Each slot is issued at most once while it is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear every slot |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free slot exists |
| disp_tag | output | TAG_W | Tag that the next dispatch receives (tail index) |
| disp_s1_rdy | input | 1 | First source carries a value |
| disp_s1_val | input | DATA_W | First source value |
| disp_s1_tag | input | TAG_W | First source producer tag |
| disp_s2_rdy | input | 1 | Second source carries a value |
| disp_s2_val | input | DATA_W | Second source value |
| disp_s2_tag | input | TAG_W | Second source producer tag |
| disp_dest | input | REG_W | Destination register |
| disp_op | input | OP_W | Operation code |
| iss_valid | output | 1 | A slot is sent to the ALU this cycle |
| iss_tag | output | TAG_W | Tag of the issued slot |
| iss_a | output | DATA_W | First operand |
| iss_b | output | DATA_W | Second operand |
| iss_op | output | OP_W | Operation code |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the producing slot |
| res_val | input | DATA_W | Result value |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_dest | output | REG_W | Retiring destination register |
| ret_val | output | DATA_W | Retiring value |

## Verification
On every cycle, the assertions check the following local rules:
- the pointers never overflow or underflow;
- a slot is issued only with both operands present, and only once;
- the issue grant is at most one-hot;
- a matching broadcast fills a waiting operand and completes its producer;
- a flush leaves every slot empty;
- retirement advances the head by one.

Other properties depend on whole instruction streams, and only the bench's scenarios can show them. These include oldest-first selection among several ready slots, same-cycle forwarding at dispatch, refusal while full, and in-order retirement of correct values. To reach them, the bench runs long mixes of dependent and independent dispatches. It holds back ALU results so that the buffer fills, and it issues flushes while slots are in flight.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int ROB_DEPTH = 8;
  parameter int TAG_W     = $clog2(ROB_DEPTH);
  parameter int PTR_W     = TAG_W + 1;
  parameter int DATA_W    = 16;
  parameter int REG_W     = 5;
  parameter int OP_W      = 3;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic  rdy;
    data_t val;
    tag_t  tag;
  } src_t;

  typedef struct packed {
    logic             busy;
    logic             issued;
    logic             done;
    data_t            value;
    src_t             s1;
    src_t             s2;
    logic [REG_W-1:0] dest;
    logic [OP_W-1:0]  op;
  } rob_ent_t;

  // Fill a waiting source from a broadcast whose tag matches.
  function automatic src_t grab(src_t s, logic v, tag_t t, data_t d);
    src_t r;
    r = s;
    if (v && !s.rdy && (s.tag == t)) begin
      r.rdy = 1'b1;
      r.val = d;
    end
    return r;
  endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
  import rob_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  logic       pop,
  output tag_t       head_idx,
  output tag_t       tail_idx,
  output logic       full,
  output logic       empty
);
  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic             head_en, tail_en;

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[TAG_W] != tail_q[TAG_W]) &&
                    (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]);

  assign head_en = flush | pop;
  assign tail_en = flush | push;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
    end else begin
      if (pop)  head_d = head_q + PTR_W'(1);
      if (push) tail_d = tail_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (head_en) begin
      head_q <= head_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (tail_en) begin
      tail_q <= tail_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R10
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     wr_en,
  input  rob_ent_t wr_ent,
  input  logic     iss_take,
  input  logic     ret_take,
  input  logic     res_v,
  input  tag_t     res_tag,
  input  data_t    res_val,
  output rob_ent_t ent,
  output logic     ready
);
  localparam tag_t MY_TAG = TAG_W'(IDX);

  rob_ent_t ent_q, ent_d;
  logic     ent_en;

  assign ent   = ent_q;
  assign ready = ent_q.busy && !ent_q.issued && ent_q.s1.rdy && ent_q.s2.rdy;
  assign ent_en = flush | wr_en | iss_take | ret_take | (res_v & ent_q.busy);

  always_comb begin
    ent_d = ent_q;
    if (ent_q.busy) begin
      ent_d.s1 = grab(ent_q.s1, res_v, res_tag, res_val);
      ent_d.s2 = grab(ent_q.s2, res_v, res_tag, res_val);
      if (res_v && (res_tag == MY_TAG)) begin
        ent_d.done  = 1'b1;
        ent_d.value = res_val;
      end
      if (iss_take) ent_d.issued = 1'b1;
      if (ret_take) ent_d.busy   = 1'b0;
    end
    if (wr_en) ent_d = wr_ent;
    if (flush) ent_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (ent_en) begin
      ent_q <= ent_d;
    end
  end

  AST_ISSUE_NEEDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_take |-> (ent_q.s1.rdy && ent_q.s2.rdy)); // R4
  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_take |-> (ent_q.busy && !ent_q.issued)); // R11
  AST_CAPTURE_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_q.busy && !ent_q.s1.rdy && res_v && (res_tag == ent_q.s1.tag) &&
     !flush && !wr_en && !ret_take)
    |=> (ent_q.s1.rdy && (ent_q.s1.val == $past(res_val)))); // R6
  AST_CAPTURE_S2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_q.busy && !ent_q.s2.rdy && res_v && (res_tag == ent_q.s2.tag) &&
     !flush && !wr_en && !ret_take)
    |=> (ent_q.s2.rdy && (ent_q.s2.val == $past(res_val)))); // R6
  AST_RESULT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_q.busy && res_v && (res_tag == MY_TAG) && !flush && !wr_en && !ret_take)
    |=> (ent_q.done && (ent_q.value == $past(res_val)))); // R8
  AST_FLUSH_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ent_q.busy); // R10
endmodule

// File: rtl/rob_pick.sv
module rob_pick
  import rob_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROB_DEPTH-1:0] ready,
  input  tag_t                 head,
  output logic                 valid,
  output tag_t                 idx
);
  logic [ROB_DEPTH-1:0] grant;

  // Scan from the head so the oldest ready slot wins.
  always_comb begin
    tag_t j;
    valid = 1'b0;
    idx   = '0;
    grant = '0;
    for (int k = 0; k < ROB_DEPTH; k++) begin
      j = head + TAG_W'(k);
      if (!valid && ready[j]) begin
        valid    = 1'b1;
        idx      = j;
        grant[j] = 1'b1;
      end
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ready[idx]); // R4
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_valid,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              disp_s1_rdy,
  input  logic [DATA_W-1:0] disp_s1_val,
  input  logic [TAG_W-1:0]  disp_s1_tag,
  input  logic              disp_s2_rdy,
  input  logic [DATA_W-1:0] disp_s2_val,
  input  logic [TAG_W-1:0]  disp_s2_tag,
  input  logic [REG_W-1:0]  disp_dest,
  input  logic [OP_W-1:0]   disp_op,
  output logic              iss_valid,
  output logic [TAG_W-1:0]  iss_tag,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b,
  output logic [OP_W-1:0]   iss_op,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_val,
  output logic              ret_valid,
  output logic [REG_W-1:0]  ret_dest,
  output logic [DATA_W-1:0] ret_val
);
  tag_t                 head_idx, tail_idx;
  logic                 full, empty;
  logic                 push, pop;
  rob_ent_t             ents [ROB_DEPTH];
  logic [ROB_DEPTH-1:0] rdy_vec;
  rob_ent_t             new_ent;
  rob_ent_t             head_ent;
  rob_ent_t             iss_ent;

  assign head_ent   = ents[head_idx];
  assign iss_ent    = ents[iss_tag];
  assign disp_ready = !full;
  assign disp_tag   = tail_idx;
  assign push       = disp_valid && !full && !flush;
  assign ret_valid  = !empty && head_ent.done;
  assign pop        = ret_valid && !flush;
  assign ret_dest   = head_ent.dest;
  assign ret_val    = head_ent.value;
  assign iss_a      = iss_ent.s1.val;
  assign iss_b      = iss_ent.s2.val;
  assign iss_op     = iss_ent.op;

  // New slot contents, with same-cycle forwarding from the result bus.
  always_comb begin
    src_t s1_in, s2_in;
    s1_in = '{rdy: disp_s1_rdy, val: disp_s1_val, tag: disp_s1_tag};
    s2_in = '{rdy: disp_s2_rdy, val: disp_s2_val, tag: disp_s2_tag};
    new_ent        = '0;
    new_ent.busy   = 1'b1;
    new_ent.s1     = grab(s1_in, res_valid, res_tag, res_val);
    new_ent.s2     = grab(s2_in, res_valid, res_tag, res_val);
    new_ent.dest   = disp_dest;
    new_ent.op     = disp_op;
  end

  rob_ptrs u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (push),
    .pop      (pop),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .full     (full),
    .empty    (empty)
  );

  for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_slot
    rob_slot #(.IDX(i)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (push && (tail_idx == TAG_W'(i))),
      .wr_ent   (new_ent),
      .iss_take (iss_valid && (iss_tag == TAG_W'(i))),
      .ret_take (pop && (head_idx == TAG_W'(i))),
      .res_v    (res_valid),
      .res_tag  (res_tag),
      .res_val  (res_val),
      .ent      (ents[i]),
      .ready    (rdy_vec[i])
    );
  end

  rob_pick u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (rdy_vec),
    .head  (head_idx),
    .valid (iss_valid),
    .idx   (iss_tag)
  );

  AST_FULL_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && disp_valid && !flush) |=> (disp_tag == $past(disp_tag))); // R3
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush) |=> (head_idx == tag_t'($past(head_idx) + 1'b1))); // R9
endmodule

// File: tb/test_rob_core.sv
module test_rob_core;
  import rob_pkg::*;

  localparam int D    = ROB_DEPTH;
  localparam int MASK = (1 << DATA_W) - 1;
  localparam int NCYC = 4000;

  logic clk, rst_n, flush, disp_valid, disp_ready;
  logic [TAG_W-1:0]  disp_tag, disp_s1_tag, disp_s2_tag, iss_tag, res_tag;
  logic              disp_s1_rdy, disp_s2_rdy, iss_valid, res_valid, ret_valid;
  logic [DATA_W-1:0] disp_s1_val, disp_s2_val, iss_a, iss_b, res_val, ret_val;
  logic [REG_W-1:0]  disp_dest, ret_dest;
  logic [OP_W-1:0]   disp_op, iss_op;

  rob_core i_rob_core (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_busy[D], m_iss[D], m_done[D], m_val[D], m_dest[D], m_op[D];
  int m_s1v[D], m_s1val[D], m_s1tag[D], m_s2v[D], m_s2val[D], m_s2tag[D];
  int m_head, m_cnt;
  int rq_tag[$], rq_val[$];
  int fwd_hits = 0, full_tries = 0, flushes = 0, ooo_issues = 0, dead_results = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int alu(input int a, input int b, input int op);
    case (op % 4)
      0: return (a + b) & MASK;
      1: return (a - b) & MASK;
      2: return (a ^ b) & MASK;
      default: return (a | b) & MASK;
    endcase
  endfunction

  task automatic model_clear();
    for (int j = 0; j < D; j++) begin
      m_busy[j] = 0; m_iss[j] = 0; m_done[j] = 0; m_val[j] = 0;
      m_s1v[j] = 0; m_s2v[j] = 0;
    end
    m_head = 0;
    m_cnt  = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 0; disp_valid = 0;
    disp_s1_rdy = 0; disp_s1_val = 0; disp_s1_tag = 0;
    disp_s2_rdy = 0; disp_s2_val = 0; disp_s2_tag = 0;
    disp_dest = 0; disp_op = 0; res_valid = 0; res_tag = 0; res_val = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(disp_ready == 1'b1, "R1", "disp_ready", disp_ready, 1);
    check(disp_tag == 0,      "R1", "disp_tag",   disp_tag,   0);
    check(iss_valid == 1'b0,  "R1", "iss_valid",  iss_valid,  0);
    check(ret_valid == 1'b0,  "R1", "ret_valid",  ret_valid,  0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int e_ready, e_tag, e_iv, e_it, e_rv;
      int phase, hold, f, dv, rv, rt, rval;
      int cand[$];
      int s1r, s1v_, s1t, s2r, s2v_, s2t, dst, op;

      if (cyc != 0) @(negedge clk);

      // Expected outputs from current reference state
      e_ready = (m_cnt < D);
      e_tag   = (m_head + m_cnt) % D;
      e_iv = 0; e_it = 0;
      for (int k = 0; k < m_cnt; k++) begin
        int j;
        j = (m_head + k) % D;
        if (!e_iv && !m_iss[j] && m_s1v[j] && m_s2v[j]) begin
          e_iv = 1; e_it = j;
        end
      end
      e_rv = (m_cnt > 0) && m_done[m_head];

      check(disp_ready == e_ready[0], "R3", "disp_ready", disp_ready, e_ready);
      check(disp_tag == e_tag,        "R2", "disp_tag",   disp_tag,   e_tag);
      check(iss_valid == e_iv[0],     "R4", "iss_valid",  iss_valid,  e_iv);
      if (e_iv && iss_valid) begin
        check(iss_tag == e_it,            "R5", "iss_tag", iss_tag, e_it);
        check(iss_a == m_s1val[e_it],     "R6", "iss_a",   iss_a,   m_s1val[e_it]);
        check(iss_b == m_s2val[e_it],     "R6", "iss_b",   iss_b,   m_s2val[e_it]);
        check(iss_op == m_op[e_it],       "R4", "iss_op",  iss_op,  m_op[e_it]);
        if (e_it != m_head) ooo_issues++;
      end
      check(ret_valid == e_rv[0], "R9", "ret_valid", ret_valid, e_rv);
      if (e_rv && ret_valid) begin
        check(ret_dest == m_dest[m_head], "R9", "ret_dest", ret_dest, m_dest[m_head]);
        check(ret_val == m_val[m_head],   "R8", "ret_val",  ret_val,  m_val[m_head]);
      end

      // Stimulus
      phase = (cyc / 500) % 4;
      case (phase)
        1:       hold = ($urandom % 4) != 0;
        2:       hold = ($urandom % 10) < 3;
        default: hold = 0;
      endcase
      f  = (phase == 2) && (m_cnt > 0) && (($urandom % 30) == 0);
      dv = (phase == 3) ? 1 : (($urandom % 10) < 7);

      rv = 0; rt = 0; rval = 0;
      if (!hold && rq_tag.size() > 0) begin
        rv = 1; rt = rq_tag.pop_front(); rval = rq_val.pop_front();
      end

      for (int j = 0; j < D; j++)
        if (m_busy[j] && !m_done[j]) cand.push_back(j);
      s1r = (cand.size() == 0) || (($urandom % 2) == 0);
      s2r = (cand.size() == 0) || (($urandom % 3) == 0);
      s1t = (cand.size() == 0) ? 0 : cand[$urandom % cand.size()];
      s2t = (cand.size() == 0) ? 0 : cand[$urandom % cand.size()];
      s1v_ = $urandom & MASK;
      s2v_ = $urandom & MASK;
      dst = $urandom % (1 << REG_W);
      op  = $urandom % (1 << OP_W);

      flush = f[0];
      disp_valid = dv[0];
      disp_s1_rdy = s1r[0]; disp_s1_val = DATA_W'(s1v_); disp_s1_tag = TAG_W'(s1t);
      disp_s2_rdy = s2r[0]; disp_s2_val = DATA_W'(s2v_); disp_s2_tag = TAG_W'(s2t);
      disp_dest = REG_W'(dst); disp_op = OP_W'(op);
      res_valid = rv[0]; res_tag = TAG_W'(rt); res_val = DATA_W'(rval);

      // Reference state update
      if (f) begin
        flushes++;
        if (rv) dead_results++;
        model_clear();
        rq_tag.delete();
        rq_val.delete();
      end else begin
        if (rv) begin
          for (int j = 0; j < D; j++) begin
            if (m_busy[j]) begin
              if (!m_s1v[j] && m_s1tag[j] == rt) begin m_s1v[j] = 1; m_s1val[j] = rval; end
              if (!m_s2v[j] && m_s2tag[j] == rt) begin m_s2v[j] = 1; m_s2val[j] = rval; end
            end
          end
          if (m_busy[rt]) begin m_done[rt] = 1; m_val[rt] = rval; end
        end
        if (e_iv) begin
          m_iss[e_it] = 1;
          rq_tag.push_back(e_it);
          rq_val.push_back(alu(m_s1val[e_it], m_s2val[e_it], m_op[e_it]));
        end
        if (e_rv) begin
          m_busy[m_head] = 0;
          m_head = (m_head + 1) % D;
          m_cnt--;
        end
        if (dv && !e_ready) full_tries++;
        if (dv && e_ready) begin
          m_busy[e_tag] = 1; m_iss[e_tag] = 0; m_done[e_tag] = 0; m_val[e_tag] = 0;
          m_dest[e_tag] = dst; m_op[e_tag] = op;
          m_s1v[e_tag] = s1r; m_s1val[e_tag] = s1r ? s1v_ : 0; m_s1tag[e_tag] = s1t;
          m_s2v[e_tag] = s2r; m_s2val[e_tag] = s2r ? s2v_ : 0; m_s2tag[e_tag] = s2t;
          if (!s1r && rv && rt == s1t) begin m_s1v[e_tag] = 1; m_s1val[e_tag] = rval; fwd_hits++; end
          if (!s2r && rv && rt == s2t) begin m_s2v[e_tag] = 1; m_s2val[e_tag] = rval; fwd_hits++; end
          m_cnt++;
        end
      end
    end

    @(negedge clk);
    flush = 0; disp_valid = 0; res_valid = 0;
    // Scenario coverage of the corner cases
    check(fwd_hits > 0,     "R7",  "forwarding_cases",  fwd_hits,     1);
    check(full_tries > 0,   "R3",  "refused_dispatch",  full_tries,   1);
    check(flushes > 0,      "R10", "flushes",           flushes,      1);
    check(dead_results > 0, "R8",  "results_in_flush",  dead_results, 1);
    check(ooo_issues > 0,   "R5",  "non_head_issues",   ooo_issues,   1);
    // R11: double issue would have shown as an iss_valid mismatch above
    check(total > NCYC, "R11", "compare_count", total, NCYC);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule